// File: doc/BRIEF.md
# Indexed Interrupt Routing Register File

This block is a 32-bit register file on a simple one-cycle bus. Software cannot address its registers directly. It reaches them through two word locations. Byte offset 0x00 holds an index, and byte offset 0x10 is a data window that reads or writes whichever internal register the index names. The registers behind the window are:

- a writable identifier,
- a read-only version word that reports the table size,
- a writable arbitration identifier,
- a parameterised table of 64-bit routing entries.

Each routing entry is reached as two consecutive 32-bit halves.

Every entry is exported on a flat vector so that a downstream interrupt dispatcher can read the routing state without any bus traffic. A bus access to any other offset is answered with an error pulse and changes nothing. Every access receives a registered response one cycle later.

Top module: `redir_regfile`

## Requirements
- R1: A write to offset 0x00 loads bits 7:0 of the write data into the index; bits 31:8 are ignored. A read of offset 0x00 returns the index, zero-extended to 32 bits.
- R2: Each request with `req_valid` high produces `rsp_valid` high in the following cycle only. That response carries the read data, or zero for a write. With no request, `rsp_valid` stays low.
- R3: A request to any offset other than 0x00 or 0x10 produces `rsp_err` together with `rsp_valid`, returns zero data, and modifies no register.
- R4: Index 0x00 holds the identifier in bits 31:24. A write updates only the identifier, and the read value has bits 23:0 at zero.
- R5: Index 0x01 reads as `NUM_ENTRIES-1` in bits 23:16 and `VERSION` in bits 7:0, with all other bits zero. Writes to it change nothing.
- R6: Index 0x02 holds the arbitration identifier in bits 31:24, laid out like R4. It is writable and resets to `ID_INIT`.
- R7: Table entry n is reached at index 0x10+2n for bits 31:0 and at 0x11+2n for bits 63:32. It appears on `entries_flat[64n+63:64n]`.
- R8: Entry writes force the reserved bits to zero. The low half keeps only the bits in mask 0x0001AFFF: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, trigger 15 and mask 16. The high half keeps only bits 31:24, the destination.
- R9: After reset, the index is 0, the identifier and the arbitration identifier both equal `ID_INIT`, and every entry reads 0x00000000_00010000, which is the mask bit set and all other bits zero.
- R10: An index that is neither 0x00 to 0x02 nor inside the table reads as zero. A write to such an index changes no register and no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_err | output | 1 | Illegal offset, valid with rsp_valid |
| rsp_rdata | output | 32 | Registered read data |
| entries_flat | output | 64*NUM_ENTRIES | All routing entries, entry n at bits 64n+63:64n |

## Verification
The bench builds the block with `NUM_ENTRIES` set to 4, `ID_INIT` set to 0x3C and `VERSION` set to 0x20. With only four entries, the first and last entries and index 0x18, the first undefined index just past the table, are all reachable in a short run. The size field of the version word then reads back as 3. Because the initial identifier is a recognisable nonzero value, the bench can show that the arbitration identifier copies it at reset and that writes aimed at the version word or at undefined indices leave both identifiers and every entry untouched.

// File: rtl/redir_pkg.sv
package redir_pkg;

    typedef enum logic [2:0] {
        RK_ID   = 3'd0,
        RK_VER  = 3'd1,
        RK_ARB  = 3'd2,
        RK_TAB  = 3'd3,
        RK_NONE = 3'd4
    } reg_kind_e;

    // bus window byte offsets
    localparam logic [7:0] WIN_INDEX_OFF = 8'h00;
    localparam logic [7:0] WIN_DATA_OFF  = 8'h10;

    // internal index map
    localparam logic [7:0] IDX_ID   = 8'h00;
    localparam logic [7:0] IDX_VER  = 8'h01;
    localparam logic [7:0] IDX_ARB  = 8'h02;
    localparam int         TAB_BASE = 16;

    // writable bits of each entry half
    localparam logic [31:0] LO_KEEP  = 32'h0001_AFFF;
    localparam logic [31:0] HI_KEEP  = 32'hFF00_0000;
    localparam logic [31:0] LO_RESET = 32'h0001_0000;
    localparam logic [31:0] HI_RESET = 32'h0000_0000;

endpackage

// File: rtl/redir_index_decode.sv
module redir_index_decode
    import redir_pkg::*;
#(
    parameter int NUM_ENTRIES = 24,
    localparam int ENT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [7:0]       idx,
    output reg_kind_e        kind,
    output logic [ENT_W-1:0] ent,
    output logic             hi
);

    localparam int TAB_END = TAB_BASE + 2 * NUM_ENTRIES;

    logic [7:0] rel;

    always_comb begin
        rel  = idx - 8'(TAB_BASE);
        ent  = rel[ENT_W:1];
        hi   = idx[0];
        kind = RK_NONE;
        if (idx == IDX_ID) begin
            kind = RK_ID;
        end else if (idx == IDX_VER) begin
            kind = RK_VER;
        end else if (idx == IDX_ARB) begin
            kind = RK_ARB;
        end else if (int'(idx) >= TAB_BASE && int'(idx) < TAB_END) begin
            kind = RK_TAB;
        end
    end

endmodule

// File: rtl/redir_entry.sv
module redir_entry
    import redir_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output logic [63:0] entry
);

    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
    } entry_t;

    entry_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (wr_lo) ent_d.lo = wdata & LO_KEEP;
        if (wr_hi) ent_d.hi = wdata & HI_KEEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q.lo <= LO_RESET;
            ent_q.hi <= HI_RESET;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign entry = ent_q;

    // R10
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(ent_q.lo));

    // R10
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(ent_q.hi));

endmodule

// File: rtl/redir_regfile.sv
module redir_regfile
    import redir_pkg::*;
#(
    parameter int          NUM_ENTRIES = 24,
    parameter logic [7:0]  ID_INIT     = 8'h00,
    parameter logic [7:0]  VERSION     = 8'h11,
    localparam int         ENT_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int         FLAT_W      = 64 * NUM_ENTRIES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_offset,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic [FLAT_W-1:0] entries_flat
);

    if (ID_INIT == 8'hFF) begin : g_bad_id
        $error("ID_INIT must be below 0xFF");
    end
    if (NUM_ENTRIES < 2 || NUM_ENTRIES > 120) begin : g_bad_size
        $error("NUM_ENTRIES must lie in 2..120");
    end

    localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENTRIES - 1), 8'h00, VERSION};

    typedef struct packed {
        logic [7:0]  sel;
        logic [7:0]  id;
        logic [7:0]  arb;
        logic        vld;
        logic        err;
        logic [31:0] rdata;
    } win_state_t;

    win_state_t st_d, st_q;

    reg_kind_e        kind;
    logic [ENT_W-1:0] ent;
    logic             ent_hi;
    logic [63:0]      ent_arr [NUM_ENTRIES];
    logic             at_index, at_data, tab_we;
    logic [31:0]      sel_rd;

    redir_index_decode #(.NUM_ENTRIES(NUM_ENTRIES)) u_decode (
        .idx  (st_q.sel),
        .kind (kind),
        .ent  (ent),
        .hi   (ent_hi)
    );

    assign at_index = (req_offset == WIN_INDEX_OFF);
    assign at_data  = (req_offset == WIN_DATA_OFF);
    assign tab_we   = req_valid && req_write && at_data && (kind == RK_TAB);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
        logic hit;
        assign hit = tab_we && (int'(ent) == i);
        redir_entry u_entry (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (hit && !ent_hi),
            .wr_hi (hit && ent_hi),
            .wdata (req_wdata),
            .entry (ent_arr[i])
        );
        assign entries_flat[64*i +: 64] = ent_arr[i];
    end

    always_comb begin
        case (kind)
            RK_ID:   sel_rd = {st_q.id, 24'h0};
            RK_VER:  sel_rd = VER_WORD;
            RK_ARB:  sel_rd = {st_q.arb, 24'h0};
            RK_TAB:  sel_rd = ent_hi ? ent_arr[ent][63:32] : ent_arr[ent][31:0];
            default: sel_rd = 32'h0;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.vld   = req_valid;
        st_d.err   = 1'b0;
        st_d.rdata = 32'h0;
        if (req_valid) begin
            if (at_index) begin
                if (req_write) st_d.sel   = req_wdata[7:0];
                else           st_d.rdata = {24'h0, st_q.sel};
            end else if (at_data) begin
                if (req_write) begin
                    if (kind == RK_ID)  st_d.id  = req_wdata[31:24];
                    if (kind == RK_ARB) st_d.arb = req_wdata[31:24];
                end else begin
                    st_d.rdata = sel_rd;
                end
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.id  <= ID_INIT;
            st_q.arb <= ID_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.vld;
    assign rsp_err   = st_q.err;
    assign rsp_rdata = st_q.rdata;

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3
    bad_offset_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !at_index && !at_data) |=> (rsp_err && rsp_valid && rsp_rdata == 32'h0));

    // R3
    bad_offset_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !at_index && !at_data) |=> $stable(st_q.sel));

    // R5
    ver_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && at_data && st_q.sel == IDX_VER)
            |=> ($stable(st_q.id) && $stable(st_q.arb)));

    // R1
    index_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && at_index) |=> (rsp_rdata[31:8] == 24'h0));

endmodule

// File: tb/redir_regfile_bench.sv
module redir_regfile_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NE         = 4;
    localparam logic [7:0] IDV = 8'h3C;
    localparam logic [7:0] VER = 8'h20;
    localparam int NV         = 40;

    typedef struct packed {
        logic        wr;
        logic [7:0]  off;
        logic [31:0] data;
        logic [31:0] exp;
        logic        err;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 32'h0,         32'h0,         1'b0}, // R9 index resets to 0
        '{1'b0, 8'h10, 32'h0,         32'h3C00_0000, 1'b0}, // R9 id reset
        '{1'b1, 8'h00, 32'h1,         32'h0,         1'b0}, // R1
        '{1'b0, 8'h10, 32'h0,         32'h0003_0020, 1'b0}, // R5
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0,         1'b0}, // R5 write ignored
        '{1'b0, 8'h10, 32'h0,         32'h0003_0020, 1'b0}, // R5
        '{1'b1, 8'h00, 32'h2,         32'h0,         1'b0}, // R1
        '{1'b0, 8'h10, 32'h0,         32'h3C00_0000, 1'b0}, // R6 arb reset
        '{1'b1, 8'h10, 32'hA5FF_FFFF, 32'h0,         1'b0}, // R6
        '{1'b0, 8'h10, 32'h0,         32'hA500_0000, 1'b0}, // R6
        '{1'b1, 8'h00, 32'h0,         32'h0,         1'b0}, // R1
        '{1'b1, 8'h10, 32'h7E12_3456, 32'h0,         1'b0}, // R4
        '{1'b0, 8'h10, 32'h0,         32'h7E00_0000, 1'b0}, // R4
        '{1'b1, 8'h00, 32'h12,        32'h0,         1'b0}, // R7 entry1 low
        '{1'b0, 8'h10, 32'h0,         32'h0001_0000, 1'b0}, // R9 mask set
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0,         1'b0}, // R8
        '{1'b0, 8'h10, 32'h0,         32'h0001_AFFF, 1'b0}, // R8
        '{1'b1, 8'h00, 32'h13,        32'h0,         1'b0}, // R7 entry1 high
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0,         1'b0}, // R8
        '{1'b0, 8'h10, 32'h0,         32'hFF00_0000, 1'b0}, // R8
        '{1'b1, 8'h00, 32'h17,        32'h0,         1'b0}, // R7 last entry high
        '{1'b1, 8'h10, 32'hAB00_0000, 32'h0,         1'b0}, // R7
        '{1'b0, 8'h10, 32'h0,         32'hAB00_0000, 1'b0}, // R7
        '{1'b1, 8'h00, 32'h16,        32'h0,         1'b0}, // R7 last entry low
        '{1'b1, 8'h10, 32'h0000_0931, 32'h0,         1'b0}, // R7
        '{1'b0, 8'h10, 32'h0,         32'h0000_0931, 1'b0}, // R7 mask cleared
        '{1'b1, 8'h00, 32'h18,        32'h0,         1'b0}, // R10 past table
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0,         1'b0}, // R10
        '{1'b0, 8'h10, 32'h0,         32'h0,         1'b0}, // R10
        '{1'b1, 8'h00, 32'hFF,        32'h0,         1'b0}, // R10
        '{1'b0, 8'h10, 32'h0,         32'h0,         1'b0}, // R10
        '{1'b0, 8'h00, 32'h0,         32'h0000_00FF, 1'b0}, // R1
        '{1'b1, 8'h00, 32'h1234_5617, 32'h0,         1'b0}, // R1 upper bits dropped
        '{1'b0, 8'h00, 32'h0,         32'h0000_0017, 1'b0}, // R1
        '{1'b0, 8'h04, 32'h0,         32'h0,         1'b1}, // R3
        '{1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0,         1'b1}, // R3
        '{1'b0, 8'h00, 32'h0,         32'h0000_0017, 1'b0}, // R3 index kept
        '{1'b0, 8'h14, 32'h0,         32'h0,         1'b1}, // R3
        '{1'b1, 8'h00, 32'h0,         32'h0,         1'b0}, // R1
        '{1'b0, 8'h10, 32'h0,         32'h7E00_0000, 1'b0}  // R3 id kept
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [7:0]       req_offset = 8'h0;
    logic [31:0]      req_wdata = 32'h0;
    logic             rsp_valid, rsp_err;
    logic [31:0]      rsp_rdata;
    logic [64*NE-1:0] entries_flat;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    redir_regfile #(.NUM_ENTRIES(NE), .ID_INIT(IDV), .VERSION(VER)) u_redir_regfile (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_offset   (req_offset),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_err      (rsp_err),
        .rsp_rdata    (rsp_rdata),
        .entries_flat (entries_flat)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [7:0] off, input logic [31:0] d,
                          output logic [31:0] rd, output logic e, output logic v);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = w;
        req_offset = off;
        req_wdata  = d;
        @(negedge clk);
        rd = rsp_rdata;
        e  = rsp_err;
        v  = rsp_valid;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic check_entries(input logic [63:0] e0, input logic [63:0] e1,
                                 input logic [63:0] e2, input logic [63:0] e3, input string tag);
        check(entries_flat[63:0]    === e0, tag, entries_flat[63:0],    e0);
        check(entries_flat[127:64]  === e1, tag, entries_flat[127:64],  e1);
        check(entries_flat[191:128] === e2, tag, entries_flat[191:128], e2);
        check(entries_flat[255:192] === e3, tag, entries_flat[255:192], e3);
    endtask

    localparam logic [63:0] ENT_RST = 64'h0000_0000_0001_0000;

    initial begin
        logic [31:0] rd;
        logic        e, v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state of the table and response outputs
        check(rsp_valid === 1'b0, "R9 rsp_valid idle", 64'(rsp_valid), 64'h0);
        check_entries(ENT_RST, ENT_RST, ENT_RST, ENT_RST, "R9 entries after reset");

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].off, VECS[i].data, rd, e, v);
            check(v === 1'b1, $sformatf("R2 vector %0d valid", i), 64'(v), 64'h1);
            check(rd === VECS[i].exp, $sformatf("R1-map vector %0d data", i), 64'(rd), 64'(VECS[i].exp));
            check(e === VECS[i].err, $sformatf("R3 vector %0d err", i), 64'(e), 64'(VECS[i].err));
        end

        // R2 response lasts one cycle only
        @(negedge clk);
        check(rsp_valid === 1'b0, "R2 valid drops", 64'(rsp_valid), 64'h0);

        // R7 R8 R10 flat export: entry 1 and 3 written, 0 and 2 untouched
        check_entries(ENT_RST, 64'hFF00_0000_0001_AFFF, ENT_RST, 64'hAB00_0000_0000_0931,
                      "R7 flat export");

        // R9 second reset restores everything
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_entries(ENT_RST, ENT_RST, ENT_RST, ENT_RST, "R9 entries after re-reset");
        access(1'b0, 8'h00, 32'h0, rd, e, v);
        check(rd === 32'h0, "R9 index after re-reset", 64'(rd), 64'h0);
        access(1'b1, 8'h00, 32'h2, rd, e, v);
        access(1'b0, 8'h10, 32'h0, rd, e, v);
        check(rd === 32'h3C00_0000, "R6 arb after re-reset", 64'(rd), 64'h3C00_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule